// File: doc/BRIEF.md
# Multicore Reset and Start Control Registers

This block is a memory-mapped register set that governs reset and start-up of the cores in a four-core cluster. Software reaches it over a simple 32-bit register port with a single write strobe and a combinational read path. The port decodes a 4 KiB window and takes aligned word accesses only. Behind the port sit sixteen registers. These are a control word, two boot-mode words, a reset-cause word, an interrupt status word, an interrupt mask word, and ten general-purpose words that hold a start address and a context word for each secondary core.

Only a write to the control word has side effects. The block compares the old control value with the new one, and only bits that differ act. When a secondary core's enable bit flips on, a start request is issued. The request carries the core number and that core's address and context words. When the enable bit flips off, a stop request is issued. When a per-core reset bit changes, a reset pulse goes to that core. Reset bits never stay set. The two display-unit soft-reset bits also clear themselves, but they have no other effect.

Requests are single-cycle pulses on three independent channels: start, stop and core reset. When several requests are waiting on one channel, they are served one per cycle, highest core number first.

Top module: `core_rst_regs`

## Requirements
- R1: After reset, the registers read as follows: index 0 (control) reads 0x521, index 2 (reset cause) reads 0x1, index 4 (interrupt mask) reads 0x1F, and every other index reads 0. No request pulse is active.
- R2: The register index is bus_addr[11:2], and bus_addr[1:0] is ignored. Indices 0..15 are, in order: control, boot-mode A, reset cause, interrupt status, interrupt mask, boot-mode B, and general words G1..G10.
- R3: A read from an index above 15 returns 0. A write to an index above 15 changes no register.
- R4: A write to any index other than 0 stores the written word unchanged.
- R5: A control write that flips the enable bit of core c (c = 1..3, bit 21+c) from 0 to 1 queues one start pulse with up_core = c. While that pulse is shown, up_addr equals general word G(2c+1) (index 6+2c) and up_ctx equals G(2c+2) (index 7+2c). The earliest pulse appears in the cycle after the write.
- R6: A control write that flips the enable bit of core c from 1 to 0 queues one stop pulse with down_core = c. A start or stop request still waiting for that core is replaced by the new one.
- R7: When a core's enable bit flips, that core's reset bit (bit 13+c) is stored as 0, and no reset pulse is produced for that core by that write.
- R8: A change of a core reset bit (core c = 0..3, bit 13+c) queues one reset pulse with crst_core = c. The bit is stored as 0.
- R9: The display-unit soft-reset bits (bits 3 and 12) are stored as 0 after any control write, and they produce no pulse.
- R10: Each channel presents at most one pulse per cycle. When several cores wait on a channel, the highest core number is served first, and the next one follows in the next cycle. The three channels run independently of each other.
- R11: All other control bits are stored as written. Rewriting an enable bit with its current value produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| up_req | output | 1 | Start request pulse |
| up_core | output | 2 | Core number of the start request |
| up_addr | output | 32 | Start address for the requested core |
| up_ctx | output | 32 | Context word for the requested core |
| down_req | output | 1 | Stop request pulse |
| down_core | output | 2 | Core number of the stop request |
| crst_req | output | 1 | Core reset pulse |
| crst_core | output | 2 | Core number of the reset pulse |

## Verification
Several properties are checked on every cycle:
- the self-clearing of reset and display bits;
- the immunity of stored state to out-of-window writes;
- plain storage for non-control indices;
- the highest-first service order on each channel;
- that a start and a stop are never shown for the same core at once.

Other properties only the bench scenarios can show. These are the exact mapping of general words onto start addresses, the suppression of reset pulses when an enable bit also flips, and the number and order of pulses after each write. To cover them, the bench sweeps every enable pattern against every reset-bit pattern and compares each of the following cycles against an arithmetic model.

// File: rtl/crr_pkg.sv
package crr_pkg;
    localparam int NUM_CORES   = 4;
    localparam int NUM_GPR     = 10;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 12;
    localparam int NUM_FIXED   = 6;
    localparam int NUM_REGS    = NUM_FIXED + NUM_GPR;
    localparam int IDX_W       = ADDR_W - 2;
    localparam int REG_IW      = $clog2(NUM_REGS);
    localparam int CID_W       = $clog2(NUM_CORES);
    localparam int NUM_CHAN    = 3;

    localparam int IDX_CTRL    = 0;
    localparam int IDX_CAUSE   = 2;
    localparam int IDX_IMASK   = 4;
    localparam int IDX_GPR0    = NUM_FIXED;

    localparam int RST_LSB     = 13;
    localparam int EN_LSB      = 21;
    localparam int DISP_A      = 3;
    localparam int DISP_B      = 12;

    localparam logic [DATA_W-1:0] RV_CTRL  = DATA_W'(32'h0000_0521);
    localparam logic [DATA_W-1:0] RV_CAUSE = DATA_W'(32'h0000_0001);
    localparam logic [DATA_W-1:0] RV_IMASK = DATA_W'(32'h0000_001F);

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [NUM_REGS-1:0][DATA_W-1:0] regbank_t;

    typedef struct packed {
        regbank_t regs;
    } rf_state_t;
endpackage

// File: rtl/crr_regfile.sv
module crr_regfile
    import crr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  word_t                wr_data,
    input  logic [IDX_W-1:0]     rd_idx,
    output word_t                rd_data,
    output regbank_t             regs_o,
    output logic [NUM_CORES-1:0] ev_on,
    output logic [NUM_CORES-1:0] ev_off,
    output logic [NUM_CORES-1:0] ev_rst
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

    rf_state_t st_d, st_q;
    word_t     cur_d, chg_d;
    logic      wr_ok;

    assign wr_ok = wr_en && (wr_idx <= LAST_IDX);

    always_comb begin
        st_d   = st_q;
        ev_on  = '0;
        ev_off = '0;
        ev_rst = '0;
        cur_d  = wr_data;
        chg_d  = st_q.regs[IDX_CTRL] ^ wr_data;
        if (wr_ok) begin
            if (wr_idx == IDX_W'(IDX_CTRL)) begin
                for (int c = 1; c < NUM_CORES; c++) begin
                    if (chg_d[EN_LSB + c]) begin
                        if (cur_d[EN_LSB + c]) ev_on[c]  = 1'b1;
                        else                   ev_off[c] = 1'b1;
                        cur_d[RST_LSB + c] = 1'b0;
                        chg_d[RST_LSB + c] = 1'b0;
                    end
                end
                for (int c = 0; c < NUM_CORES; c++) begin
                    if (chg_d[RST_LSB + c]) begin
                        ev_rst[c] = 1'b1;
                        cur_d[RST_LSB + c] = 1'b0;
                    end
                end
                if (chg_d[DISP_A]) cur_d[DISP_A] = 1'b0;
                if (chg_d[DISP_B]) cur_d[DISP_B] = 1'b0;
                st_d.regs[IDX_CTRL] = cur_d;
            end else begin
                st_d.regs[wr_idx[REG_IW-1:0]] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.regs            <= '0;
            st_q.regs[IDX_CTRL]  <= RV_CTRL;
            st_q.regs[IDX_CAUSE] <= RV_CAUSE;
            st_q.regs[IDX_IMASK] <= RV_IMASK;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = (rd_idx <= LAST_IDX) ? st_q.regs[rd_idx[REG_IW-1:0]] : '0;
    assign regs_o  = st_q.regs;

    AST_RESET_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (st_q.regs[IDX_CTRL] == RV_CTRL && st_q.regs[IDX_IMASK] == RV_IMASK)); // R1
    AST_OOR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx > LAST_IDX) |=> $stable(st_q.regs)); // R3
    AST_PLAIN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != IDX_W'(IDX_CTRL) && wr_idx <= LAST_IDX)
        |=> st_q.regs[$past(wr_idx[REG_IW-1:0])] == $past(wr_data)); // R4
    AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.regs[IDX_CTRL][RST_LSB +: NUM_CORES] == '0); // R8
    AST_DISP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.regs[IDX_CTRL][DISP_A] && !st_q.regs[IDX_CTRL][DISP_B]); // R9
    AST_TOGGLE_NO_RST: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_on | ev_off) & ev_rst) == '0); // R7
endmodule

// File: rtl/crr_pick.sv
module crr_pick
    import crr_pkg::*;
#(
    parameter int N   = NUM_CORES,
    parameter int IDW = CID_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   set_i,
    input  logic [N-1:0]   cancel_i,
    output logic           req_o,
    output logic [IDW-1:0] id_o
);
    logic [N-1:0] pend_d, pend_q, gnt;

    always_comb begin
        id_o  = '0;
        gnt   = '0;
        req_o = |pend_q;
        for (int i = 0; i < N; i++) begin
            if (pend_q[i]) id_o = IDW'(i);
        end
        if (req_o) gnt[id_o] = 1'b1;
        pend_d = (pend_q & ~gnt & ~cancel_i) | set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    AST_HIGHEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> ((pend_q >> id_o) == N'(1))); // R10
    AST_SERVED_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !set_i[id_o]) |=> !pend_q[$past(id_o)]); // R10
endmodule

// File: rtl/core_rst_regs.sv
module core_rst_regs
    import crr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        up_req,
    output logic [1:0]  up_core,
    output logic [31:0] up_addr,
    output logic [31:0] up_ctx,
    output logic        down_req,
    output logic [1:0]  down_core,
    output logic        crst_req,
    output logic [1:0]  crst_core
);
    regbank_t             regs;
    logic [NUM_CORES-1:0] ev_on, ev_off, ev_rst;
    logic [NUM_CORES-1:0] ch_set    [NUM_CHAN];
    logic [NUM_CORES-1:0] ch_cancel [NUM_CHAN];
    logic                 ch_req    [NUM_CHAN];
    logic [CID_W-1:0]     ch_id     [NUM_CHAN];
    logic [REG_IW-1:0]    addr_idx, ctx_idx;

    crr_regfile u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we),
        .wr_idx  (bus_addr[ADDR_W-1:2]),
        .wr_data (bus_wdata),
        .rd_idx  (bus_addr[ADDR_W-1:2]),
        .rd_data (bus_rdata),
        .regs_o  (regs),
        .ev_on   (ev_on),
        .ev_off  (ev_off),
        .ev_rst  (ev_rst)
    );

    assign ch_set[0]    = ev_on;
    assign ch_cancel[0] = ev_off;
    assign ch_set[1]    = ev_off;
    assign ch_cancel[1] = ev_on;
    assign ch_set[2]    = ev_rst;
    assign ch_cancel[2] = '0;

    for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chan
        crr_pick #(.N(NUM_CORES), .IDW(CID_W)) u_pick (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (ch_set[g]),
            .cancel_i (ch_cancel[g]),
            .req_o    (ch_req[g]),
            .id_o     (ch_id[g])
        );
    end

    assign up_req    = ch_req[0];
    assign up_core   = ch_id[0];
    assign down_req  = ch_req[1];
    assign down_core = ch_id[1];
    assign crst_req  = ch_req[2];
    assign crst_core = ch_id[2];

    assign addr_idx = REG_IW'(IDX_GPR0 + 2 * int'(up_core));
    assign ctx_idx  = REG_IW'(IDX_GPR0 + 2 * int'(up_core) + 1);
    assign up_addr  = up_req ? regs[addr_idx] : '0;
    assign up_ctx   = up_req ? regs[ctx_idx]  : '0;

    AST_NO_START_CORE0: assert property (@(posedge clk) disable iff (!rst_n)
        up_req |-> up_core != '0); // R5
    AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (up_req && down_req) |-> up_core != down_core); // R6
endmodule

// File: tb/sim_core_rst_regs.sv
`timescale 1ns/1ps
module sim_core_rst_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        up_req, down_req, crst_req;
    logic [1:0]  up_core, down_core, crst_core;
    logic [31:0] up_addr, up_ctx;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    core_rst_regs u0 (.*);

    always #2 clk = ~clk;

    function automatic logic [31:0] gval(int idx);
        return 32'h5A00_0000 + idx * 32'h111;
    endfunction

    function automatic int top_bit(logic [3:0] v);
        int r = 0;
        for (int i = 0; i < 4; i++) if (v[i]) r = i;
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(bus_rdata === exp, tag, bus_rdata, exp);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [3:0] exp_on, exp_off, exp_rst;
        logic [2:0] prev_en;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset image and quiet outputs
        chk({up_req, down_req, crst_req} === 3'b000, "R1 pulses idle", {29'd0, up_req, down_req, crst_req}, 0);
        for (int i = 0; i < 16; i++) begin
            logic [31:0] e;
            e = (i == 0) ? 32'h521 : (i == 2) ? 32'h1 : (i == 4) ? 32'h1F : 32'h0;
            rd(12'(i * 4), e, "R1 reset value");
        end
        // R3: out-of-window accesses
        rd(12'h040, 0, "R3 read beyond last index");
        rd(12'hFFC, 0, "R3 read top of window");
        wr(12'h040, 32'hDEAD_BEEF);
        wr(12'h050, 32'hDEAD_BEEF);
        rd(12'h000, 32'h521, "R3 control untouched");
        rd(12'h010, 32'h1F, "R3 mask untouched");
        // R4 and R2: plain storage and byte-lane independence
        for (int i = 1; i < 16; i++) wr(12'(i * 4), gval(i));
        for (int i = 1; i < 16; i++) rd(12'(i * 4 + (i % 4)), gval(i), "R4 R2 plain store");
        chk({up_req, down_req, crst_req} === 3'b000, "R4 no side effect", {29'd0, up_req, down_req, crst_req}, 0);

        // Sweep: every enable pattern against every reset pattern
        prev_en = 3'b000;
        for (int en = 0; en < 8; en++) begin
            for (int rs = 0; rs < 16; rs++) begin
                logic [31:0] w, exp_ctrl;
                logic [2:0]  tog;
                w = 32'h0000_0521 | (32'(en) << 22) | (32'(rs) << 13);
                if (rs[0]) w = w | 32'h0000_1008;
                tog     = prev_en ^ 3'(en);
                exp_on  = {tog & 3'(en), 1'b0};
                exp_off = {tog & ~3'(en), 1'b0};
                exp_rst = 4'(rs) & ~{tog, 1'b0};
                exp_ctrl = w & ~32'h0001_E008 & ~32'h0000_1000;
                prev_en = 3'(en);
                wr(12'h000, w);
                for (int k = 0; k < 5; k++) begin
                    #1;
                    chk(up_req === (exp_on != 0), "R5 R11 start pulse presence", {31'd0, up_req}, {31'd0, exp_on != 0});
                    if (exp_on != 0) begin
                        int c;
                        c = top_bit(exp_on);
                        chk(up_core === 2'(c), "R10 start order", {30'd0, up_core}, c);
                        chk(up_addr === gval(6 + 2 * c), "R5 start address", up_addr, gval(6 + 2 * c));
                        chk(up_ctx === gval(7 + 2 * c), "R5 start context", up_ctx, gval(7 + 2 * c));
                        exp_on[c] = 1'b0;
                    end
                    chk(down_req === (exp_off != 0), "R6 stop pulse presence", {31'd0, down_req}, {31'd0, exp_off != 0});
                    if (exp_off != 0) begin
                        int c;
                        c = top_bit(exp_off);
                        chk(down_core === 2'(c), "R6 R10 stop order", {30'd0, down_core}, c);
                        exp_off[c] = 1'b0;
                    end
                    chk(crst_req === (exp_rst != 0), "R8 R7 reset pulse presence", {31'd0, crst_req}, {31'd0, exp_rst != 0});
                    if (exp_rst != 0) begin
                        int c;
                        c = top_bit(exp_rst);
                        chk(crst_core === 2'(c), "R8 R10 reset order", {30'd0, crst_core}, c);
                        exp_rst[c] = 1'b0;
                    end
                    @(negedge clk);
                end
                rd(12'h000, exp_ctrl, "R9 R8 R7 R11 stored control");
            end
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule